// File: doc/BRIEF.md
# Addressed Serial Volume Command Receiver

This block sits behind three slow serial pins (bit clock, data and latch) and turns 16-bit command words into two stereo attenuation settings. Every pin is brought into the system clock domain through a two-flop synchronizer. Rising edges are found by comparing the synchronized level with its previous value. Bits are shifted in most significant first. A rising latch edge hands the last sixteen bits to a command decoder.

The decoder compares the two address bits of the word with two static strap pins, so that up to four receivers can share one bus. A two-bit channel field then picks which of the two channel registers takes the 8-bit attenuation code. For each channel the block gives the raw code, a mute flag, the attenuation in 1 dB steps and a one-cycle strobe when that register is written. Reset mutes both channels.

Top module: `vol_cmd_rx`

## Requirements
- R1: Each rising edge of `ser_clk_i` shifts `ser_dat_i` into the word. The first bit sent becomes bit 15 and the last becomes bit 0.
- R2: The command takes effect only on a rising edge of `ser_lat_i`. The channel outputs change within 12 system clocks of that edge.
- R3: A latch that follows fewer than 16 serial clock edges is ignored. When more than 16 edges precede the latch, only the last 16 bits are used.
- R4: Bit 13 is compared with `addr_sel1_i` and bit 12 with `addr_sel2_i`. If either differs, both channel registers keep their values and neither strobe pulses.
- R5: The channel field is bits 9:8. 00 writes both channels, 01 writes only left, 10 writes only right, and 11 writes neither.
- R6: Bits 15, 14, 11 and 10 have no effect on the result.
- R7: The code is bits 7:0. Codes 0x00 to 0x50 give mute low and a dB output equal to the code, so 0x50 is 80 dB of attenuation.
- R8: Codes 0x51 to 0xFF give mute high and a dB output of 127.
- R9: After reset both codes read 0xFF, both mute flags are high, both dB outputs are 127 and no strobe is high.
- R10: A channel's update strobe is high for exactly one system clock each time its register is written, and it is never high otherwise.
- R11: The bit count is cleared on every latch edge, so a short burst after a valid latch cannot re-apply the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous, idles high) |
| ser_dat_i | input | 1 | Serial data |
| ser_lat_i | input | 1 | Latch enable (low while bits are sent, rising edge applies) |
| addr_sel1_i | input | 1 | Strap compared with word bit 13 |
| addr_sel2_i | input | 1 | Strap compared with word bit 12 |
| left_code_o | output | 8 | Left attenuation code |
| left_mute_o | output | 1 | Left muted |
| left_db_o | output | 7 | Left attenuation in dB, 127 when muted |
| left_upd_o | output | 1 | One-cycle strobe on left write |
| right_code_o | output | 8 | Right attenuation code |
| right_mute_o | output | 1 | Right muted |
| right_db_o | output | 7 | Right attenuation in dB, 127 when muted |
| right_upd_o | output | 1 | One-cycle strobe on right write |

## Verification
The bench sends every one of the 256 codes and tests the boundary between 0x50 and 0x51. A decoder with an off-by-one limit would mute at 80 dB or pass 0x51 as an attenuation. It sends all sixteen pairings of word address and strap pins, and all four channel modes. An inverted compare or a swapped channel bit would then write the wrong register or a register on another device. Short bursts, over-long bursts and a burst right after a valid latch test the bit counter. A counter that does not saturate, or is not cleared, would drop good words or replay stale ones. Strobes are counted and checked for double pulses, which catches a level in place of a pulse.

// File: rtl/volrx_pkg.sv
// Shared constants and types for the serial volume command receiver.
package volrx_pkg;
    localparam int WORD_W   = 16;   // bits per command word
    localparam int CODE_W   = 8;    // attenuation code width
    localparam int DB_W     = 7;    // decoded dB output width
    localparam int MAX_STEP = 80;   // largest code that still attenuates
    localparam int N_CHAN   = 2;    // index 0 = left, 1 = right

    // Channel selection field (word bits 9:8); the values are part of the command format.
    typedef enum logic [1:0] {
        CH_BOTH  = 2'b00,
        CH_LEFT  = 2'b01,
        CH_RIGHT = 2'b10,
        CH_NONE  = 2'b11
    } chan_sel_e;

    // Layout of a command word, most significant field first.
    typedef struct packed {
        logic [1:0] spare_hi;   // bits 15:14, ignored
        logic [1:0] addr;       // bits 13:12, {strap1, strap2}
        logic [1:0] spare_mid;  // bits 11:10, ignored
        chan_sel_e  chan;       // bits 9:8
        logic [7:0] code;       // bits 7:0
    } cmd_word_t;
endpackage

// File: rtl/volrx_pin_sync.sv
// Synchronizes a group of asynchronous pins and flags their rising edges.
// Assumes each pin stays stable for at least two system clocks per level.
// The flops reset to IDLE so that a pin idling at that level makes no edge.
module volrx_pin_sync #(
    parameter int   N_PINS = 3,
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_i,
    output logic [N_PINS-1:0] level_o,
    output logic [N_PINS-1:0] rise_o
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Synchronizer chain: the newest sample enters at bit 0.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= {STAGES{IDLE}};
            else        chain_q <= {chain_q[STAGES-2:0], pins_i[p]};
        end

        // Previous synchronized level, used for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= IDLE;
            else        prev_q <= chain_q[STAGES-1];
        end

        assign level_o[p] = chain_q[STAGES-1];
        assign rise_o[p]  = chain_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/volrx_shifter.sv
// Shifts serial bits in MSB first and, on a latch edge, emits the last WORD_W
// bits when at least WORD_W bits were counted. Assumes a bit edge and a latch
// edge never arrive in the same system clock.
module volrx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              shift_i,
    input  logic              latch_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    // Shift register: the oldest bit leaves at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg_q <= '0;
        else if (shift_i) shreg_q <= {shreg_q[WORD_W-2:0], bit_i};
    end

    // Bit counter: saturates at WORD_W and clears on every latch edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (latch_i)               cnt_q <= '0;
        else if (shift_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end

    // Capture the word and raise the load pulse on a latch after a full word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            load_o <= 1'b0;
        end else begin
            load_o <= latch_i && (cnt_q == FULL);
            if (latch_i && cnt_q == FULL) word_o <= shreg_q;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL); // R3
    AST_LOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(latch_i)); // R2
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i |=> cnt_q == '0); // R11
endmodule

// File: rtl/volrx_decode.sv
// Combinational command decoder: compares the address field with the straps
// and turns the channel field into per-channel write enables.
module volrx_decode
    import volrx_pkg::*;
(
    input  logic            load_i,
    input  cmd_word_t       word_i,
    input  logic [1:0]      strap_i,
    output logic [N_CHAN-1:0] wr_o,
    output logic [CODE_W-1:0] code_o
);
    logic addr_hit;
    logic [N_CHAN-1:0] sel;

    // Address match against the straps; bit 13 to strap 1, bit 12 to strap 2.
    assign addr_hit = (word_i.addr == strap_i);

    // Channel field to channel mask (bit 0 left, bit 1 right).
    always_comb begin
        unique case (word_i.chan)
            CH_BOTH:  sel = 2'b11;
            CH_LEFT:  sel = 2'b01;
            CH_RIGHT: sel = 2'b10;
            default:  sel = 2'b00;
        endcase
    end

    assign wr_o   = (load_i && addr_hit) ? sel : '0;
    assign code_o = word_i.code;
endmodule

// File: rtl/volrx_channel.sv
// One channel's attenuation register with its decoded outputs and write strobe.
// The code resets to RESET_CODE (a mute code) and changes only on wr_i.
module volrx_channel #(
    parameter int CODE_W     = 8,
    parameter int DB_W       = 7,
    parameter int MAX_STEP   = 80,
    parameter int RESET_CODE = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              mute_o,
    output logic [DB_W-1:0]   db_o,
    output logic              upd_o
);
    localparam logic [CODE_W-1:0] LIMIT   = CODE_W'(MAX_STEP);
    localparam logic [DB_W-1:0]   DB_MUTE = '1;

    // Attenuation register and its one-cycle write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= CODE_W'(RESET_CODE);
            upd_o  <= 1'b0;
        end else begin
            upd_o <= wr_i;
            if (wr_i) code_o <= code_i;
        end
    end

    // Decoded view: codes above the step range mean mute.
    assign mute_o = (code_o > LIMIT);
    assign db_o   = mute_o ? DB_MUTE : DB_W'(code_o);

    AST_CODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> upd_o); // R10
    AST_MUTE_DB: assert property (@(posedge clk) disable iff (!rst_n)
        mute_o |-> db_o == DB_MUTE); // R8
endmodule

// File: rtl/vol_cmd_rx.sv
// Top level of the addressed serial volume command receiver.
// Chain: pin synchronizer -> shifter -> decoder -> two channel registers.
module vol_cmd_rx
    import volrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_lat_i,
    input  logic              addr_sel1_i,
    input  logic              addr_sel2_i,
    output logic [CODE_W-1:0] left_code_o,
    output logic              left_mute_o,
    output logic [DB_W-1:0]   left_db_o,
    output logic              left_upd_o,
    output logic [CODE_W-1:0] right_code_o,
    output logic              right_mute_o,
    output logic [DB_W-1:0]   right_db_o,
    output logic              right_upd_o
);
    localparam int PIN_CLK = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_LAT = 2;

    logic [2:0]          lvl, rise;
    logic [WORD_W-1:0]   word;
    logic                load;
    logic [N_CHAN-1:0]   wr;
    logic [CODE_W-1:0]   new_code;
    logic [CODE_W-1:0]   code   [N_CHAN];
    logic [N_CHAN-1:0]   mute, upd;
    logic [DB_W-1:0]     db     [N_CHAN];

    volrx_pin_sync #(.N_PINS(3), .STAGES(2), .IDLE(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  ({ser_lat_i, ser_dat_i, ser_clk_i}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    volrx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (lvl[PIN_DAT]),
        .shift_i (rise[PIN_CLK]),
        .latch_i (rise[PIN_LAT]),
        .word_o  (word),
        .load_o  (load)
    );

    volrx_decode u_dec (
        .load_i  (load),
        .word_i  (cmd_word_t'(word)),
        .strap_i ({addr_sel1_i, addr_sel2_i}),
        .wr_o    (wr),
        .code_o  (new_code)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        volrx_channel #(
            .CODE_W     (CODE_W),
            .DB_W       (DB_W),
            .MAX_STEP   (MAX_STEP),
            .RESET_CODE ((1 << CODE_W) - 1)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (wr[c]),
            .code_i (new_code),
            .code_o (code[c]),
            .mute_o (mute[c]),
            .db_o   (db[c]),
            .upd_o  (upd[c])
        );
    end

    assign left_code_o  = code[0];
    assign left_mute_o  = mute[0];
    assign left_db_o    = db[0];
    assign left_upd_o   = upd[0];
    assign right_code_o = code[1];
    assign right_mute_o = mute[1];
    assign right_db_o   = db[1];
    assign right_upd_o  = upd[1];

    AST_WRITE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr != '0) |-> load); // R4
    AST_STROBE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (left_upd_o || right_upd_o) |-> $past(load)); // R2
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        left_upd_o |=> !left_upd_o); // R10
endmodule

// File: tb/vol_cmd_rx_bench.sv
// Self-checking bench: sweeps codes, addresses and channel modes with a
// reference model computed from the command format.
module vol_cmd_rx_bench;
    localparam int HOLD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1, ser_dat = 1'b0, ser_lat = 1'b1;
    logic a1 = 1'b0, a2 = 1'b0;
    logic [7:0] l_code, r_code;
    logic       l_mute, r_mute, l_upd, r_upd;
    logic [6:0] l_db, r_db;

    int errors = 0, checks = 0;
    int l_cnt = 0, r_cnt = 0, dbl = 0;
    logic l_prev = 1'b0, r_prev = 1'b0;
    logic [7:0] exp_l = 8'hFF, exp_r = 8'hFF;
    int exp_lc = 0, exp_rc = 0;

    always #10 clk = ~clk;

    vol_cmd_rx u_vol_cmd_rx (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_lat_i(ser_lat),
        .addr_sel1_i(a1), .addr_sel2_i(a2),
        .left_code_o(l_code), .left_mute_o(l_mute), .left_db_o(l_db), .left_upd_o(l_upd),
        .right_code_o(r_code), .right_mute_o(r_mute), .right_db_o(r_db), .right_upd_o(r_upd)
    );

    // Strobe monitor: counts pulses and flags back-to-back highs (R10).
    always @(negedge clk) begin
        if (l_upd) l_cnt++;
        if (r_upd) r_cnt++;
        if ((l_upd && l_prev) || (r_upd && r_prev)) dbl++;
        l_prev = l_upd;
        r_prev = r_upd;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] expv(input logic [7:0] c);
        logic m;
        m = (c > 8'd80);
        return {c, m, m ? 7'd127 : c[6:0]};
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " left"},  {l_code, l_mute, l_db}, expv(exp_l));
        chk({tag, " right"}, {r_code, r_mute, r_db}, expv(exp_r));
        chk({tag, " strobes"}, {l_cnt[15:0], r_cnt[15:0]}, {exp_lc[15:0], exp_rc[15:0]});
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_clk = 1'b0;
            ser_dat = v[i];
            repeat (HOLD) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HOLD) @(negedge clk);
        end
    endtask

    // Full transaction: bits with latch low, then rising latch, then settle.
    task automatic xfer(input logic [31:0] v, input int n);
        ser_lat = 1'b0;
        repeat (HOLD) @(negedge clk);
        send_bits(v, n);
        ser_lat = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    // Reference model of a full 16-bit word (R4, R5, R6, R7).
    task automatic model(input logic [15:0] w);
        if (w[13] == a1 && w[12] == a2) begin
            if (w[9:8] == 2'b00 || w[9:8] == 2'b01) begin exp_l = w[7:0]; exp_lc++; end
            if (w[9:8] == 2'b00 || w[9:8] == 2'b10) begin exp_r = w[7:0]; exp_rc++; end
        end
    endtask

    task automatic word(input logic [15:0] w, input string tag);
        xfer({16'h0, w}, 16);
        model(w);
        check_all(tag);
    endtask

    initial begin
        repeat (200000 - 10) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R9 reset strobes", {31'd0, l_upd | r_upd}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R9 after reset");

        // R7 R8 R1: every code to both channels, alternating the spare bits (R6).
        for (int c = 0; c < 256; c++) begin
            logic [15:0] w;
            w = {2'b00, 2'b00, 2'b00, 2'b00, 8'(c)};
            if (c[0]) w[15:14] = 2'b11;
            if (c[1]) w[11:10] = 2'b10;
            if (c[2]) w[15] = 1'b1;
            word(w, (c == 80 || c == 81) ? "R7 R8 boundary" : "R7 R8 R6 R1 sweep");
        end

        // R5: each channel mode with distinct codes.
        for (int m = 0; m < 4; m++) begin
            word({4'b0000, 2'b00, 2'(m), 8'(10 + m)}, "R5 channel mode");
            word({4'b0000, 2'b00, 2'(m), 8'(40 + m)}, "R5 channel mode again");
        end

        // R4: all strap and address pairings.
        for (int s = 0; s < 4; s++) begin
            a1 = s[1];
            a2 = s[0];
            repeat (6) @(negedge clk);
            for (int a = 0; a < 4; a++)
                word({2'b00, 2'(a), 2'b00, 2'b00, 8'(s * 16 + a * 3)}, "R4 address filter");
        end
        a1 = 1'b0;
        a2 = 1'b0;
        repeat (6) @(negedge clk);
        word(16'h0005, "R4 setup");

        // R3: fifteen bits then latch is ignored.
        xfer({16'h0, 16'h0033}, 15);
        check_all("R3 short burst");
        // R3: twenty bits, the last sixteen apply.
        xfer({12'h0, 4'hF, 16'h0021}, 20);
        model(16'h0021);
        check_all("R3 long burst");
        // R11: valid word, then a short burst must not replay it.
        word(16'h0044, "R11 setup");
        exp_l = 8'h44; exp_r = 8'h44;
        xfer({16'h0, 16'h0007}, 5);
        check_all("R11 short after latch");
        // R2: bits without a latch edge change nothing.
        ser_lat = 1'b0;
        send_bits({16'h0, 16'h0012}, 16);
        repeat (12) @(negedge clk);
        check_all("R2 no latch yet");
        ser_lat = 1'b1;
        repeat (12) @(negedge clk);
        model(16'h0012);
        check_all("R2 latch applies");

        chk("R10 single-cycle strobes", dbl, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule